// File: doc/BRIEF.md
# Interrupt Destination Resolver with Rotation

This block turns the addressing fields of an interrupt message into a set of target processor interrupt units. It takes a destination byte, a flag that picks physical or logical addressing and a flag that picks lowest-priority delivery. Every unit's logical-destination byte arrives as a slice of one packed input vector. One clock after a request, the block returns a target bitmap with a valid flag and an error flag.

In physical addressing a unit is named by its index, and the byte value 0xFF reaches every unit. In logical addressing the block compares the destination byte against each unit's logical byte. When lowest-priority delivery is requested in logical addressing, the block does not compare unit priorities. A persistent rotation counter, taken modulo the number of matched units, picks a single unit from the matched set.

Top module: `intr_dest_resolver`

## Requirements
- R1: While reset is held, and on the first cycle after it, outValid, outMask and outError are all zero. Reset also clears the rotation counter to zero, so the first lowest-priority pick after reset goes to the lowest-indexed matched unit.
- R2: A request sampled with reqValid high gives outValid high on the next clock edge, with that request's result. A cycle with reqValid low gives outValid, outMask and outError all zero on the next edge.
- R3: In physical addressing (reqLogical=0, reqLowPri=0), a destination of 0xFF sets every bit of outMask.
- R4: In physical addressing with any destination other than 0xFF, outMask bit d is set for destination d when d < NUM_UNITS. A destination at or above NUM_UNITS gives an all-zero mask, with outValid still high and outError low.
- R5: Physical addressing with lowest-priority delivery (reqLogical=0, reqLowPri=1) gives outError=1 and an all-zero outMask. The rotation counter does not change.
- R6: In logical addressing with fixed delivery (reqLogical=1, reqLowPri=0), outMask bit i is set exactly when the AND of reqDest and unit i's logical byte (unitLogicalIds bits 8i+7..8i) is nonzero.
- R7: In logical addressing with lowest-priority delivery and at least one matched unit, outMask is one-hot. It selects the k-th matched unit in ascending index order, counting from 0, where k = counter mod matchCount.
- R8: The rotation counter goes up by one only after a lowest-priority logical request that has a non-empty match set. No other request and no idle cycle changes it.
- R9: A lowest-priority logical request that matches no unit gives an all-zero mask, outError=0 and outValid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqDest | input | 8 | Destination byte |
| reqLogical | input | 1 | 1 = logical addressing, 0 = physical |
| reqLowPri | input | 1 | 1 = lowest-priority delivery, 0 = fixed |
| unitLogicalIds | input | 8*NUM_UNITS | Logical byte of unit i in bits 8i+7..8i |
| outValid | output | 1 | Result valid, one cycle after the request |
| outMask | output | NUM_UNITS | Target bitmap, bit i = unit i |
| outError | output | 1 | Unsupported mode combination |

## Verification
The hardest case to reach from the ports is the rotation counter wrapping against a match set whose size keeps changing. The pick depends on every earlier lowest-priority request that had a non-empty match. The stimulus runs long streams of lowest-priority logical requests and, between them, changes the logical bytes so that the match count moves between one and all units. It mixes in empty-match, physical-error and fixed-delivery requests that must leave the counter untouched. A mid-run reset then shows that the counter starts again from zero.

// File: rtl/intr_dest_pkg.sv
package intr_dest_pkg;
  localparam int DEST_W = 8;
  localparam logic [DEST_W-1:0] DEST_ALL = 8'hFF;

  typedef struct packed {
    logic load;     // capture a result this cycle
    logic errFlag;  // unsupported physical lowest-priority
    logic rotate;   // lowest-priority logical pick
  } ctrl_strb_t;
endpackage

// File: rtl/intr_dest_ctrl.sv
module intr_dest_ctrl
  import intr_dest_pkg::*;
#(
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqLogical,
  input  logic              reqLowPri,
  input  logic              matchAny,
  output ctrl_strb_t        strb,
  output logic [OFFS_W-1:0] rotOffset
);
  always_comb begin
    strb.load    = reqValid;
    strb.errFlag = reqValid && !reqLogical && reqLowPri;
    strb.rotate  = reqValid && reqLogical && reqLowPri;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rotOffset <= '0;
    end else if (strb.rotate && matchAny) begin
      rotOffset <= rotOffset + 1'b1;
    end
  end
endmodule

// File: rtl/intr_dest_datapath.sv
module intr_dest_datapath
  import intr_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int OFFS_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrl_strb_t                  strb,
  input  logic [DEST_W-1:0]           reqDest,
  input  logic                        reqLogical,
  input  logic [NUM_UNITS*DEST_W-1:0] unitLogicalIds,
  input  logic [OFFS_W-1:0]           rotOffset,
  output logic                        matchAny,
  output logic                        outValid,
  output logic [NUM_UNITS-1:0]        outMask,
  output logic                        outError
);
  localparam int CNT_W = $clog2(NUM_UNITS + 1);

  logic [NUM_UNITS-1:0] logicHits;
  logic [NUM_UNITS-1:0] physMask;
  logic [NUM_UNITS-1:0] pickMask;
  logic [NUM_UNITS-1:0] nextMask;
  logic [CNT_W-1:0]     hitCount;
  logic [OFFS_W-1:0]    divisor;
  logic [OFFS_W-1:0]    pickIdx;

  genvar g;
  generate
    for (g = 0; g < NUM_UNITS; g++) begin : gUnit
      assign logicHits[g] = |(unitLogicalIds[g*DEST_W +: DEST_W] & reqDest);
      assign physMask[g]  = (reqDest == DEST_ALL) || (reqDest == DEST_W'(g));
    end
  endgenerate

  assign matchAny = |logicHits;
  assign hitCount = CNT_W'($countones(logicHits));
  assign divisor  = (hitCount == '0) ? OFFS_W'(1) : OFFS_W'(hitCount);
  assign pickIdx  = rotOffset % divisor;

  // walk the hits in ascending order and keep the pickIdx-th one
  always_comb begin
    int seen;
    seen     = 0;
    pickMask = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (logicHits[i]) begin
        if (OFFS_W'(seen) == pickIdx) pickMask[i] = 1'b1;
        seen = seen + 1;
      end
    end
  end

  always_comb begin
    if (strb.errFlag)     nextMask = '0;
    else if (strb.rotate) nextMask = pickMask;
    else if (reqLogical)  nextMask = logicHits;
    else                  nextMask = physMask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outMask  <= '0;
      outError <= 1'b0;
    end else begin
      outValid <= strb.load;
      outMask  <= strb.load ? nextMask : '0;
      outError <= strb.errFlag;
    end
  end
endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
  import intr_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int OFFS_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic [7:0]              reqDest,
  input  logic                    reqLogical,
  input  logic                    reqLowPri,
  input  logic [NUM_UNITS*8-1:0]  unitLogicalIds,
  output logic                    outValid,
  output logic [NUM_UNITS-1:0]    outMask,
  output logic                    outError
);
  ctrl_strb_t        strb;
  logic [OFFS_W-1:0] rotOffset;
  logic              matchAny;

  intr_dest_ctrl #(.OFFS_W(OFFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqLogical(reqLogical),
    .reqLowPri(reqLowPri), .matchAny(matchAny), .strb(strb), .rotOffset(rotOffset)
  );

  intr_dest_datapath #(.NUM_UNITS(NUM_UNITS), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqDest(reqDest),
    .reqLogical(reqLogical), .unitLogicalIds(unitLogicalIds),
    .rotOffset(rotOffset), .matchAny(matchAny), .outValid(outValid),
    .outMask(outMask), .outError(outError)
  );
endmodule

// File: rtl/intr_dest_checker.sv
module intr_dest_checker #(
  parameter int NUM_UNITS = 8,
  parameter int OFFS_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reqValid,
  input logic [7:0]           reqDest,
  input logic                 reqLogical,
  input logic                 reqLowPri,
  input logic                 matchAny,
  input logic [OFFS_W-1:0]    rotOffset,
  input logic                 outValid,
  input logic [NUM_UNITS-1:0] outMask,
  input logic                 outError
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (outMask == '0 && !outError));
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqLogical && !reqLowPri && reqDest == 8'hFF) |=> (outMask == '1));
  a_r5_error_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqLogical && reqLowPri) |=> (outError && outMask == '0));
  a_r7_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqLogical && reqLowPri) |=> $onehot0(outMask));
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqLogical && reqLowPri && matchAny) |=> (rotOffset == $past(rotOffset) + 1'b1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqLogical && reqLowPri && matchAny) |=> $stable(rotOffset));
endmodule

bind intr_dest_resolver intr_dest_checker #(.NUM_UNITS(NUM_UNITS), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqDest(reqDest),
  .reqLogical(reqLogical), .reqLowPri(reqLowPri), .matchAny(matchAny),
  .rotOffset(rotOffset), .outValid(outValid), .outMask(outMask), .outError(outError)
);

// File: tb/sim_intr_dest_resolver.sv
module sim_intr_dest_resolver;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reqValid = 1'b0;
  logic [7:0]     reqDest = '0;
  logic           reqLogical = 1'b0;
  logic           reqLowPri = 1'b0;
  logic [N*8-1:0] unitLogicalIds = '0;
  logic           outValid;
  logic [N-1:0]   outMask;
  logic           outError;

  int testCount = 0;
  int failCount = 0;
  int modelOffset = 0;
  logic         expValid = 1'b0;
  logic [N-1:0] expMask = '0;
  logic         expErr = 1'b0;
  string        expTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_dest_resolver #(.NUM_UNITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqDest(reqDest),
    .reqLogical(reqLogical), .reqLowPri(reqLowPri), .unitLogicalIds(unitLogicalIds),
    .outValid(outValid), .outMask(outMask), .outError(outError)
  );

  task automatic check_now();
    testCount++;
    if (outValid !== expValid || outMask !== expMask || outError !== expErr) begin
      failCount++;
      $display("FAIL %s: got v=%b m=%b e=%b, expected v=%b m=%b e=%b",
               expTag, outValid, outMask, outError, expValid, expMask, expErr);
    end
  endtask

  // reference: result for the request being driven now
  task automatic model(input logic v, input logic [7:0] d, input logic lg, input logic lp);
    int hits[$];
    expValid = v; expMask = '0; expErr = 1'b0;
    if (!v) begin expTag = "R2"; return; end
    if (!lg && lp) begin expErr = 1'b1; expTag = "R5"; return; end
    if (!lg) begin
      if (d == 8'hFF) begin expMask = '1; expTag = "R3"; end
      else begin
        expTag = "R4";
        if (int'(d) < N) expMask[d] = 1'b1;
      end
      return;
    end
    for (int i = 0; i < N; i++)
      if ((unitLogicalIds[i*8 +: 8] & d) != 0) hits.push_back(i);
    if (!lp) begin
      expTag = "R6";
      foreach (hits[j]) expMask[hits[j]] = 1'b1;
    end else if (hits.size() == 0) begin
      expTag = "R9";
    end else begin
      expTag = "R7,R8";
      expMask[hits[modelOffset % hits.size()]] = 1'b1;
      modelOffset++;
    end
  endtask

  task automatic apply(input logic v, input logic [7:0] d, input logic lg, input logic lp);
    @(negedge clk);
    check_now();
    reqValid = v; reqDest = d; reqLogical = lg; reqLowPri = lp;
    model(v, d, lg, lp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reqValid = 1'b0;
    modelOffset = 0;
    expValid = 1'b0; expMask = '0; expErr = 1'b0; expTag = "R1";
    repeat (2) begin @(negedge clk); check_now(); end
    rst_n = 1'b1;
  endtask

  task automatic set_ids(input logic [N*8-1:0] ids);
    @(negedge clk);
    check_now();
    unitLogicalIds = ids;
    model(1'b0, 8'h00, 1'b0, 1'b0);
    reqValid = 1'b0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    failCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    do_reset();  // R1
    // R3 / R4 physical fixed
    apply(1, 8'hFF, 0, 0);
    apply(1, 8'h03, 0, 0);
    apply(1, 8'h07, 0, 0);
    apply(1, 8'h08, 0, 0);
    apply(1, 8'h40, 0, 0);
    apply(0, 8'hFF, 0, 0);       // R2 idle
    apply(1, 8'h00, 0, 1);       // R5 error
    apply(1, 8'hFF, 0, 1);
    set_ids({8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01});
    apply(1, 8'h15, 1, 0);       // R6
    apply(1, 8'h00, 1, 0);
    // R7 / R8 rotation over three matches
    for (int k = 0; k < 7; k++) apply(1, 8'h32, 1, 1);
    apply(1, 8'h00, 1, 1);       // R9 empty, no advance
    apply(1, 8'h32, 1, 1);
    apply(1, 8'h01, 0, 1);       // R5 no advance
    apply(1, 8'h32, 1, 1);
    do_reset();                  // R1 counter back to zero
    set_ids({8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01});
    apply(1, 8'hA0, 1, 1);
    apply(1, 8'hA0, 1, 1);
    // mixed traffic with changing match sets
    for (int r = 0; r < 3000; r++) begin
      if (r % 16 == 0) begin
        logic [N*8-1:0] ids;
        for (int u = 0; u < N; u++)
          ids[u*8 +: 8] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
        set_ids(ids);
      end
      apply(1'($urandom_range(0, 5) != 0), 8'($urandom), 1'($urandom_range(0, 3) != 0),
            1'($urandom_range(0, 2) != 0));
    end
    apply(0, 8'h00, 0, 0);
    @(negedge clk); check_now();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule